// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes stereo audio from a three-wire serial link (bit clock, channel-select clock and serial data) and turns it into parallel samples. It is clocked by the bit clock, so every register samples the channel clock and the data line on the rising bit-clock edge. Words arrive most significant bit first in two's complement. A two-bit framing code picks one of four layouts: right-justified 16-bit, right-justified 24-bit, left-justified (16 to 24 bits), or I2S (16 to 24 bits).

Each finished word leaves the block as a signed value aligned to the top of a 24-bit bus. A channel flag and a single-cycle valid pulse go with it. The framing code is captured only while the block sits in standby, so a change on those pins during operation has no effect. After leaving standby, the block discards the partial word that ends at the first channel transition and reports only words it has seen from their start.

Top module: `aud_serial_rx`

## Requirements
- R1: The framing code `fmt` selects the layout: 2'b00 right-justified 16-bit, 2'b01 right-justified 24-bit, 2'b10 left-justified, 2'b11 I2S. Data is sampled MSB first on every rising `clk` edge.
- R2: In 2'b01 mode, the sample is the last 24 data bits sampled before the first clock edge at which `lrck` is seen at its new level.
- R3: In 2'b00 mode, the last 16 data bits before that edge appear in `smp_data[23:8]`, and `smp_data[7:0]` is zero.
- R4: In 2'b10 mode, the MSB is the bit sampled at the edge where the new `lrck` level is first seen. Up to 24 bits are kept, later bits are ignored, and the unused low bits of a shorter word are zero.
- R5: In 2'b11 mode, the MSB is the bit sampled one clock after the new `lrck` level is first seen. Up to 24 bits are kept, with zero padding as in R4.
- R6: `smp_right` is 1 for a right-channel word. In modes 2'b00, 2'b01 and 2'b10 the right channel is `lrck` low. In 2'b11 it is `lrck` high.
- R7: `smp_valid` pulses for one cycle, registered on the clock edge that detects the channel transition. In 2'b11 mode that edge is one clock later than in the other modes. `smp_data` holds its value between pulses.
- R8: `fmt` is captured on every clock while `wake` is 0 and held while `wake` is 1. A change of `fmt` while `wake` is 1 does not alter the framing.
- R9: While `wake` is 0, and for the word that ends at the first channel transition after `wake` rises, no `smp_valid` pulse is produced.
- R10: A synchronous active-high `rst` clears `smp_valid`, `smp_data` and `smp_right` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wake | input | 1 | 1 = running, 0 = standby (framing code captured) |
| fmt | input | 2 | Framing code |
| lrck | input | 1 | Channel-select clock |
| sdata | input | 1 | Serial data, MSB first |
| smp_data | output | 24 | Received sample, aligned to the top |
| smp_right | output | 1 | 1 when the sample belongs to the right channel |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A wrong bit count or a shifted capture start shows up at the first reported sample as a value scaled by a power of two or carrying a stray junk bit. That happens within one half-frame after synchronisation. A wrong edge or polarity decision flips `smp_right`, or moves the valid pulse by one clock. A framing code that leaks through during operation corrupts the very next word. Each cycle is compared with a bit-stream model, so any of these faults is caught in the cycle it first reaches the outputs.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ   = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;
endpackage

// File: rtl/aud_lr_track.sv
module aud_lr_track (
  input  logic clk,
  input  logic rst,
  input  logic lrck,
  input  logic is_i2s,
  output logic edge_o,
  output logic ended_right
);
  logic lr_s1, lr_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_s1 <= 1'b0;
      lr_s2 <= 1'b0;
    end else begin
      lr_s1 <= lrck;
      lr_s2 <= lr_s1;
    end
  end

  // I2S frames start one bit later, so its transition is seen on the delayed copy
  always_comb begin
    if (is_i2s) begin
      edge_o      = (lr_s1 != lr_s2);
      ended_right = lr_s2;
    end else begin
      edge_o      = (lrck != lr_s1);
      ended_right = ~lr_s1;
    end
  end
endmodule

// File: rtl/aud_word_cap.sv
module aud_word_cap
  import aud_rx_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd,
  input  logic              edge_i,
  input  fmt_e              fmt,
  output logic [WORD_W-1:0] word_o
);
  localparam int CW  = $clog2(WORD_W + 1);
  localparam int PAD = WORD_W - SHORT_W;

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] cap;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      cap   <= '0;
      cnt   <= '0;
    end else begin
      shreg <= {shreg[WORD_W-2:0], sd};
      if (edge_i) begin
        cap <= {sd, {(WORD_W-1){1'b0}}};
        cnt <= CW'(1);
      end else if (cnt < CW'(WORD_W)) begin
        for (int i = 0; i < WORD_W; i++) begin
          if (cnt == CW'(WORD_W - 1 - i)) cap[i] <= sd;
        end
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    case (fmt)
      FMT_RJ24: word_o = shreg;
      FMT_RJ16: word_o = {shreg[SHORT_W-1:0], {PAD{1'b0}}};
      default:  word_o = cap;
    endcase
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WORD_W)); // R4
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake,
  input  logic [1:0]        fmt,
  input  logic              lrck,
  input  logic              sdata,
  output logic [WORD_W-1:0] smp_data,
  output logic              smp_right,
  output logic              smp_valid
);
  fmt_e              fmt_q;
  logic              synced;
  logic              lr_edge;
  logic              lr_right;
  logic [WORD_W-1:0] word;

  aud_lr_track u_lr (
    .clk(clk), .rst(rst), .lrck(lrck),
    .is_i2s(fmt_q == FMT_I2S),
    .edge_o(lr_edge), .ended_right(lr_right)
  );

  aud_word_cap #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_cap (
    .clk(clk), .rst(rst), .sd(sdata), .edge_i(lr_edge),
    .fmt(fmt_q), .word_o(word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q     <= FMT_RJ16;
      synced    <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_right <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (!wake) begin
        fmt_q  <= fmt_e'(fmt);
        synced <= 1'b0;
      end else if (lr_edge) begin
        synced <= 1'b1;
        if (synced) begin
          smp_valid <= 1'b1;
          smp_data  <= word;
          smp_right <= lr_right;
        end
      end
    end
  end

  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (wake && $past(wake)) |-> (fmt_q == $past(fmt_q))); // R8
  AST_QUIET_STBY: assert property (@(posedge clk) disable iff (rst)
    !wake |=> !smp_valid); // R9
  AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(synced)); // R9
  AST_RJ16_LOW: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && fmt_q == FMT_RJ16) |-> (smp_data[WORD_W-SHORT_W-1:0] == '0)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |-> $stable(smp_data)); // R7
endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, wake, lrck, sdata;
  logic [1:0] fmt;
  logic [23:0] smp_data;
  logic smp_right, smp_valid;

  int tests = 0;
  int fails = 0;

  // reference model state
  bit lp1, lp2;
  int edges;
  bit allbits[$];
  bit cur[$];
  logic [1:0] mf;
  bit ev, er;
  logic [23:0] ed;
  bit i2s_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_serial_rx u0 (
    .clk(clk), .rst(rst), .wake(wake), .fmt(fmt), .lrck(lrck), .sdata(sdata),
    .smp_data(smp_data), .smp_right(smp_right), .smp_valid(smp_valid)
  );

  function automatic logic [23:0] build_word();
    logic [23:0] v = '0;
    int sz = allbits.size();
    if (mf == 2'b01) begin
      for (int k = 0; k < 24; k++) begin
        int idx = sz - 24 + k;
        v = {v[22:0], (idx >= 0) ? allbits[idx] : 1'b0};
      end
    end else if (mf == 2'b00) begin
      for (int k = 0; k < 16; k++) begin
        int idx = sz - 16 + k;
        v = {v[22:0], (idx >= 0) ? allbits[idx] : 1'b0};
      end
      v = v << 8;
    end else begin
      for (int k = 0; k < 24; k++)
        v = {v[22:0], (k < cur.size()) ? cur[k] : 1'b0};
    end
    return v;
  endfunction

  task automatic model_step();
    bit edge_now;
    if (rst) begin
      lp1 = 0; lp2 = 0; edges = 0; mf = 2'b00;
      allbits.delete(); cur.delete();
      ev = 0; er = 0; ed = '0;
      return;
    end
    ev = 0;
    edge_now = (mf == 2'b11) ? (lp1 != lp2) : (lrck != lp1);
    if (!wake) begin
      mf = fmt;
      edges = 0;
    end else if (edge_now) begin
      if (edges > 0) begin
        ev = 1;
        ed = build_word();
        er = (mf == 2'b11) ? lp2 : !lp1;
      end
      edges++;
    end
    if (edge_now) begin
      cur.delete();
      cur.push_back(sdata);
    end else begin
      cur.push_back(sdata);
    end
    allbits.push_back(sdata);
    if (allbits.size() > 64) void'(allbits.pop_front());
    lp2 = lp1;
    lp1 = lrck;
  endtask

  function automatic string data_tag();
    if (fmt != mf) return "R8";
    case (mf)
      2'b00: return "R3/R1";
      2'b01: return "R2/R1";
      2'b10: return "R4/R1";
      default: return "R5/R1";
    endcase
  endfunction

  task automatic compare();
    if (rst) return;
    tests++;
    if (smp_valid !== ev) begin
      fails++;
      $display("FAIL %s valid: actual %0b expected %0b", (edges <= 1) ? "R9" : "R7", smp_valid, ev);
    end
    if (ev) begin
      tests++;
      if (smp_data !== ed) begin
        fails++;
        $display("FAIL %s data: actual %h expected %h", data_tag(), smp_data, ed);
      end
      tests++;
      if (smp_right !== er) begin
        fails++;
        $display("FAIL R6 channel: actual %0b expected %0b", smp_right, er);
      end
    end
  endtask

  task automatic drive(input bit l, input bit s);
    @(negedge clk);
    compare();
    lrck = l;
    sdata = s;
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic half(input bit lvl, input int md, input int hl, input int wl, input logic [23:0] w);
    for (int i = 0; i < hl; i++) begin
      bit b = 1'($urandom_range(1));
      case (md)
        0: if (i >= hl - 16) b = w[15 - (i - (hl - 16))];
        1: if (i >= hl - 24) b = w[23 - (i - (hl - 24))];
        default: if (i < wl) b = w[wl - 1 - i];
      endcase
      if (md == 3) begin
        drive(lvl, i2s_pend);
        i2s_pend = b;
      end else begin
        drive(lvl, b);
      end
    end
  endtask

  task automatic frame(input int md, input int hl, input int wl);
    bit left_lvl = (md == 3) ? 1'b0 : 1'b1;
    half(left_lvl, md, hl, wl, 24'($urandom));
    half(!left_lvl, md, hl, wl, 24'($urandom));
  endtask

  task automatic standby(input logic [1:0] f, input int n);
    wake = 0;
    fmt = f;
    for (int i = 0; i < n; i++) drive(lrck, 1'b0);
    wake = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; wake = 0; fmt = 2'b00; lrck = 0; sdata = 0; i2s_pend = 0;
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0);
    @(negedge clk);
    tests++;
    if (smp_valid !== 1'b0 || smp_data !== 24'h0 || smp_right !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual %0b/%h/%0b expected 0/000000/0", smp_valid, smp_data, smp_right);
    end
    rst = 0;
    @(posedge clk);
    #1 model_step();

    // R3: right-justified 16-bit
    standby(2'b00, 4);
    for (int i = 0; i < 3; i++) frame(0, 32, 16);
    frame(0, 64, 16);
    // R2: right-justified 24-bit
    standby(2'b01, 4);
    for (int i = 0; i < 3; i++) frame(1, 48, 24);
    frame(1, 64, 24);
    // R4: left-justified, several word lengths, zero padding
    standby(2'b10, 4);
    frame(2, 32, 16);
    frame(2, 32, 16);
    frame(2, 48, 24);
    frame(2, 64, 20);
    frame(2, 24, 24);
    frame(2, 40, 18);
    // R5: I2S, including word length equal to half-frame
    standby(2'b11, 4);
    frame(3, 32, 16);
    frame(3, 32, 16);
    frame(3, 24, 24);
    frame(3, 16, 16);
    frame(3, 64, 22);
    frame(3, 48, 24);
    // R8: framing pins change while running
    standby(2'b10, 4);
    frame(2, 32, 24);
    fmt = 2'b01;
    frame(2, 32, 20);
    frame(2, 48, 16);
    fmt = 2'b11;
    frame(2, 32, 24);
    // R9: standby in mid-frame, then restart
    half(1'b1, 2, 32, 24, 24'h5A5A5A);
    standby(2'b11, 5);
    frame(3, 32, 24);
    frame(3, 32, 17);
    standby(2'b00, 3);
    frame(0, 32, 16);
    frame(0, 48, 16);
    drive(lrck, 1'b0);
    @(negedge clk);
    compare();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule